// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date as packed BCD bytes: seconds, minutes, hours, day of month, month, day of week and a two-digit year. A free-running oscillator enable at 32.768 kHz feeds an internal binary prescaler. The prescaler produces one tick per second, and each tick advances the counter chain. Carries ripple from seconds through minutes and hours into the date, day-of-week, month and year fields. Month lengths follow the calendar, and February has 29 days in every year divisible by four, across the range 2000 to 2099.

The hour byte holds its own format flag, so the host chooses between a 24-hour count and a 12-hour count with an AM/PM flag by writing that byte. Bit 7 of the seconds byte is a halt flag that freezes timekeeping. An external register bank writes any single field through a load port (valid, field address, data) and reads every field continuously as a byte. Legal values are the host's responsibility. The block does not check illegal dates.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. The step from 59 to 00 advances the next field by one.
- R2: With hour bit 7 = 0 (24-hour mode), bits 5:0 count 00 to 23 in BCD with the tens digit in bits 5:4. The step from 23 to 00 advances the day.
- R3: With hour bit 7 = 1 (12-hour mode), bits 4:0 hold the BCD hour 01 to 12 and bit 5 is the PM flag (midnight 0x92, 1 AM 0x81, noon 0xB2, 1 PM 0xA1, 11 PM 0xB1). 12 is followed by 01. The 11-to-12 step toggles the PM flag. The step from 11 PM to 12 AM advances the day.
- R4: Day of week (byte bits 2:0) counts 1 to 7 and then returns to 1. It advances on the same carry that advances the date.
- R5: The date wraps to 01 after 31 days in months 1, 3, 5, 7, 8, 10 and 12, and after 30 days in months 4, 6, 9 and 11. In February it wraps after 29 days when the BCD year is divisible by 4 (including 00) and after 28 days otherwise. The wrap advances the month.
- R6: The month counts 01 to 12. The wrap to 01 advances the year, and the year counts 00 to 99 and then wraps to 00.
- R7: The seconds field advances once per 2^PRESC_W cycles that have the oscillator enable high, whether or not those cycles are consecutive. A load of the seconds field clears the prescaler.
- R8: While seconds bit 7 is 1, neither the prescaler nor any time field advances.
- R9: Fixed-zero bits always read 0, even when the host writes 1 to them. These bits are minutes bit 7, hours bit 6, date bits 7:6, month bits 7:5 and day-of-week bits 7:3.
- R10: Load addresses are 0 = seconds, 1 = minutes, 2 = hours, 3 = date, 4 = month, 5 = day of week and 6 = year. A load to address 7 changes nothing. The loaded field takes the load value one cycle later, even when a tick arrives in the same cycle.
- R11: After reset the bytes read seconds 0x00, minutes 0x00, hours 0x00, date 0x01, month 0x01, day of week 0x01 and year 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| ld_valid | input | 1 | Field load strobe |
| ld_addr | input | 3 | Field address of the load |
| ld_data | input | 8 | Packed byte to load |
| sec_byte | output | 8 | Halt flag and BCD seconds |
| min_byte | output | 8 | BCD minutes |
| hour_byte | output | 8 | Mode flag, PM flag or tens, and BCD hours |
| date_byte | output | 8 | BCD day of month |
| mon_byte | output | 8 | BCD month |
| dow_byte | output | 8 | Day of week 1 to 7 |
| year_byte | output | 8 | BCD year 00 to 99 |

## Verification
The carry and wrap properties assume the host loads only legal BCD values for each field. The bench only ever loads legal values into fields that will then count. It writes all-ones patterns only to probe the fixed-zero bits, and it restores legal values before the next tick. The properties also assume the oscillator enable and the load inputs are defined from reset onward. The bench drives every input to a known level at time zero and changes inputs only on falling clock edges. It keeps loads and enables apart, except in the one case that deliberately tests a load colliding with a tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NFIELD = 7;
  localparam int AW     = 3;

  typedef enum logic [AW-1:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_DATE = 3'd3,
    FLD_MON  = 3'd4,
    FLD_DOW  = 3'd5,
    FLD_YEAR = 3'd6
  } field_e;

  // Two-digit BCD increment without wrap handling.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // BCD year divisible by four: tens*10+ones, with 10 = 2 mod 4.
  function automatic logic is_leap(input logic [7:0] y);
    logic [3:0] s;
    s = {y[6:4], 1'b0} + y[3:0];
    return (s[1:0] == 2'b00);
  endfunction

  // Length of the month in days, in BCD.
  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    logic [7:0] r;
    case (m)
      8'h02:                      r = is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  input  logic halt,
  input  logic clr,
  output logic tick
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         adv;

  assign adv  = en_in && !halt;
  assign tick = adv && (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ld_sec,
  input  logic       ld_min,
  input  logic       ld_hour,
  input  logic [7:0] ld_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic       day_carry
);
  logic [7:0] sec_d, min_d, hour_d;
  logic [7:0] sec_nx, min_nx, hour_nx;
  logic       sec_wrap, min_wrap, hour_wrap;
  logic [7:0] inc_s, inc_m, inc_h24, inc_h12;

  assign sec_wrap = (sec_q[6:0] == 7'h59);
  assign min_wrap = (min_q == 8'h59);
  assign inc_s    = bcd_inc({1'b0, sec_q[6:0]});
  assign inc_m    = bcd_inc(min_q);
  assign inc_h24  = bcd_inc({2'b00, hour_q[5:0]});
  assign inc_h12  = bcd_inc({3'b000, hour_q[4:0]});
  assign sec_nx   = sec_wrap ? {sec_q[7], 7'h00} : {sec_q[7], inc_s[6:0]};
  assign min_nx   = min_wrap ? 8'h00 : inc_m;

  // Hour step for both encodings; hour_wrap marks the start of a new day.
  always_comb begin
    hour_wrap = 1'b0;
    if (!hour_q[7]) begin
      if (hour_q[5:0] == 6'h23) begin
        hour_nx   = 8'h00;
        hour_wrap = 1'b1;
      end else begin
        hour_nx = {2'b00, inc_h24[5:0]};
      end
    end else begin
      if (hour_q[4:0] == 5'h12) begin
        hour_nx = {2'b10, hour_q[5], 5'h01};
      end else if (hour_q[4:0] == 5'h11) begin
        hour_nx   = {2'b10, ~hour_q[5], 5'h12};
        hour_wrap = hour_q[5];
      end else begin
        hour_nx = {2'b10, hour_q[5], inc_h12[4:0]};
      end
    end
  end

  assign day_carry = tick && sec_wrap && min_wrap && hour_wrap;

  always_comb begin
    sec_d  = sec_q;
    min_d  = min_q;
    hour_d = hour_q;
    if (ld_sec)                             sec_d  = ld_data;
    else if (tick)                          sec_d  = sec_nx;
    if (ld_min)                             min_d  = ld_data & 8'h7F;
    else if (tick && sec_wrap)              min_d  = min_nx;
    if (ld_hour)                            hour_d = ld_data & 8'hBF;
    else if (tick && sec_wrap && min_wrap)  hour_d = hour_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      sec_q  <= sec_d;
      min_q  <= min_d;
      hour_q <= hour_d;
    end
  end
endmodule

// File: rtl/rtc_date_core.sv
module rtc_date_core
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_adv,
  input  logic       ld_date,
  input  logic       ld_mon,
  input  logic       ld_dow,
  input  logic       ld_year,
  input  logic [7:0] ld_data,
  output logic [7:0] date_q,
  output logic [7:0] mon_q,
  output logic [7:0] dow_q,
  output logic [7:0] year_q
);
  logic [7:0] date_d, mon_d, dow_d, year_d;
  logic [7:0] date_max;
  logic       date_wrap, mon_wrap;

  assign date_max  = month_len(mon_q, year_q);
  assign date_wrap = (date_q == date_max);
  assign mon_wrap  = (mon_q == 8'h12);

  always_comb begin
    date_d = date_q;
    mon_d  = mon_q;
    dow_d  = dow_q;
    year_d = year_q;
    if (ld_date)      date_d = ld_data & 8'h3F;
    else if (day_adv) date_d = date_wrap ? 8'h01 : bcd_inc(date_q);
    if (ld_dow)       dow_d  = ld_data & 8'h07;
    else if (day_adv) dow_d  = (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
    if (ld_mon)                    mon_d = ld_data & 8'h1F;
    else if (day_adv && date_wrap) mon_d = mon_wrap ? 8'h01 : bcd_inc(mon_q);
    if (ld_year) year_d = ld_data;
    else if (day_adv && date_wrap && mon_wrap)
      year_d = (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      dow_q  <= 8'h01;
      year_q <= 8'h00;
    end else begin
      date_q <= date_d;
      mon_q  <= mon_d;
      dow_q  <= dow_d;
      year_q <= year_d;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int PRESC_W = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_en,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  output logic [7:0]    sec_byte,
  output logic [7:0]    min_byte,
  output logic [7:0]    hour_byte,
  output logic [7:0]    date_byte,
  output logic [7:0]    mon_byte,
  output logic [7:0]    dow_byte,
  output logic [7:0]    year_byte
);
  logic [NFIELD-1:0] ld_hit;
  logic              sec_tick;
  logic              day_carry;

  for (genvar i = 0; i < NFIELD; i++) begin : g_dec
    assign ld_hit[i] = ld_valid && (ld_addr == AW'(i));
  end

  rtc_prescaler #(.W(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .en_in (osc_en),
    .halt  (sec_byte[7]),
    .clr   (ld_hit[FLD_SEC]),
    .tick  (sec_tick)
  );

  rtc_time_core u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sec_tick),
    .ld_sec    (ld_hit[FLD_SEC]),
    .ld_min    (ld_hit[FLD_MIN]),
    .ld_hour   (ld_hit[FLD_HOUR]),
    .ld_data   (ld_data),
    .sec_q     (sec_byte),
    .min_q     (min_byte),
    .hour_q    (hour_byte),
    .day_carry (day_carry)
  );

  rtc_date_core u_date (
    .clk     (clk),
    .rst_n   (rst_n),
    .day_adv (day_carry),
    .ld_date (ld_hit[FLD_DATE]),
    .ld_mon  (ld_hit[FLD_MON]),
    .ld_dow  (ld_hit[FLD_DOW]),
    .ld_year (ld_hit[FLD_YEAR]),
    .ld_data (ld_data),
    .date_q  (date_byte),
    .mon_q   (mon_byte),
    .dow_q   (dow_byte),
    .year_q  (year_byte)
  );
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_valid,
  input logic [2:0] ld_addr,
  input logic [7:0] ld_data,
  input logic       sec_tick,
  input logic [7:0] sec_byte,
  input logic [7:0] min_byte,
  input logic [7:0] hour_byte,
  input logic [7:0] date_byte,
  input logic [7:0] mon_byte,
  input logic [7:0] dow_byte,
  input logic [7:0] year_byte
);
  // R1: a tick on second 59 with no seconds load returns the field to 00
  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && sec_byte[6:0] == 7'h59 && !(ld_valid && ld_addr == 3'd0)
      |=> sec_byte[6:0] == 7'h00);

  // R8: the halt flag blocks the one-second tick
  p_no_tick_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_byte[7] |-> !sec_tick);

  // R8: halted and no load leaves every field unchanged
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_byte[7] && !ld_valid
      |=> $stable(sec_byte) && $stable(min_byte) && $stable(hour_byte) &&
          $stable(date_byte) && $stable(mon_byte) && $stable(dow_byte) &&
          $stable(year_byte));

  // R9: fixed-zero bits never read 1
  p_zero_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !min_byte[7] && !hour_byte[6] && date_byte[7:6] == 2'b00 &&
    mon_byte[7:5] == 3'b000 && dow_byte[7:3] == 5'b00000);

  // R10: a seconds load wins over a coincident tick
  p_sec_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_addr == 3'd0 |=> sec_byte == $past(ld_data));

  // R10: a year load is taken as written
  p_year_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_addr == 3'd6 |=> year_byte == $past(ld_data));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_valid  (ld_valid),
  .ld_addr   (ld_addr),
  .ld_data   (ld_data),
  .sec_tick  (sec_tick),
  .sec_byte  (sec_byte),
  .min_byte  (min_byte),
  .hour_byte (hour_byte),
  .date_byte (date_byte),
  .mon_byte  (mon_byte),
  .dow_byte  (dow_byte),
  .year_byte (year_byte)
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
  localparam int PW  = 2;
  localparam int DIV = 1 << PW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       ld_valid = 1'b0;
  logic [2:0] ld_addr = 3'd0;
  logic [7:0] ld_data = 8'h00;
  logic [7:0] sec_byte, min_byte, hour_byte, date_byte, mon_byte, dow_byte, year_byte;

  int  total = 0;
  int  bad = 0;
  bit  ended = 1'b0;

  always #10 clk = ~clk;

  rtc_calendar #(.PRESC_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
    .sec_byte(sec_byte), .min_byte(min_byte), .hour_byte(hour_byte),
    .date_byte(date_byte), .mon_byte(mon_byte), .dow_byte(dow_byte),
    .year_byte(year_byte)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] enc12(input int h24);
    int h;
    h = h24 % 12;
    if (h == 0) h = 12;
    return 8'h80 | ((h24 >= 12) ? 8'h20 : 8'h00) | bcd(h);
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic enables(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_en = 1'b1;
      @(negedge clk); osc_en = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic one_sec();
    for (int i = 0; i < DIV; i++) begin
      @(negedge clk); osc_en = 1'b1;
    end
    @(negedge clk); osc_en = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                         input logic [7:0] w, input logic [7:0] h, input logic [7:0] mi,
                         input logic [7:0] s);
    load(3'd6, y); load(3'd4, mo); load(3'd3, d); load(3'd5, w);
    load(3'd2, h); load(3'd1, mi); load(3'd0, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "sec", sec_byte, 8'h00);   chk("R11", "min", min_byte, 8'h00);
    chk("R11", "hour", hour_byte, 8'h00); chk("R11", "date", date_byte, 8'h01);
    chk("R11", "mon", mon_byte, 8'h01);   chk("R11", "dow", dow_byte, 8'h01);
    chk("R11", "year", year_byte, 8'h00);

    // R1 sweep over a full hour in 24-hour mode
    set_all(8'h10, 8'h05, 8'h10, 8'h02, 8'h00, 8'h00, 8'h00);
    for (int n = 1; n <= 3600; n++) begin
      one_sec();
      chk("R1", "sec", sec_byte, bcd(n % 60));
      chk("R1", "min", min_byte, bcd((n / 60) % 60));
    end
    chk("R1", "hour carry", hour_byte, 8'h01);

    // R2 R4 R6 full wrap on the last second of a century
    set_all(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    one_sec();
    chk("R2", "hour", hour_byte, 8'h00); chk("R1", "min", min_byte, 8'h00);
    chk("R4", "dow", dow_byte, 8'h01);   chk("R5", "date", date_byte, 8'h01);
    chk("R6", "mon", mon_byte, 8'h01);   chk("R6", "year", year_byte, 8'h00);

    // R2 24-hour sweep, R3 12-hour sweep, R4 day-of-week stepping
    for (int h = 0; h < 24; h++) begin
      set_all(8'h10, 8'h05, 8'h10, 8'h03, bcd(h), 8'h59, 8'h59);
      one_sec();
      chk("R2", "hour24", hour_byte, bcd((h + 1) % 24));
      chk("R4", "dow24", dow_byte, (h == 23) ? 8'h04 : 8'h03);
      set_all(8'h10, 8'h05, 8'h10, 8'h07, enc12(h), 8'h59, 8'h59);
      one_sec();
      chk("R3", "hour12", hour_byte, enc12((h + 1) % 24));
      chk("R3", "date12", date_byte, (h == 23) ? 8'h11 : 8'h10);
      chk("R4", "dow12", dow_byte, (h == 23) ? 8'h01 : 8'h07);
    end

    // R5 R6 month lengths in common and leap years
    for (int yi = 0; yi < 3; yi++) begin
      int y;
      y = (yi == 0) ? 23 : (yi == 1) ? 24 : 0;
      for (int m = 1; m <= 12; m++) begin
        int ml;
        ml = mdays(m, y);
        set_all(bcd(y), bcd(m), bcd(ml - 1), 8'h01, 8'h23, 8'h59, 8'h59);
        one_sec();
        chk("R5", "no wrap", date_byte, bcd(ml));
        set_all(bcd(y), bcd(m), bcd(ml), 8'h01, 8'h23, 8'h59, 8'h59);
        one_sec();
        chk("R5", "wrap", date_byte, 8'h01);
        chk("R6", "mon", mon_byte, bcd((m == 12) ? 1 : m + 1));
        chk("R6", "year", year_byte, bcd((m == 12) ? (y + 1) % 100 : y));
      end
    end

    // R7 gapped enables and prescaler clear on seconds load
    set_all(8'h10, 8'h05, 8'h10, 8'h01, 8'h08, 8'h00, 8'h00);
    enables(DIV - 1, 2);
    chk("R7", "before tick", sec_byte, 8'h00);
    enables(1, 2);
    chk("R7", "gapped tick", sec_byte, 8'h01);
    enables(DIV - 2, 0);
    load(3'd0, 8'h10);
    enables(DIV - 1, 1);
    chk("R7", "cleared", sec_byte, 8'h10);
    enables(1, 0);
    chk("R7", "after clear", sec_byte, 8'h11);

    // R8 halt freezes everything
    load(3'd1, 8'h59);
    load(3'd0, 8'h85);
    enables(3 * DIV, 0);
    chk("R8", "sec halted", sec_byte, 8'h85);
    chk("R8", "min halted", min_byte, 8'h59);
    load(3'd0, 8'h05);
    one_sec();
    chk("R8", "resumed", sec_byte, 8'h06);

    // R9 fixed-zero bits
    load(3'd1, 8'hFF); chk("R9", "min", min_byte, 8'h7F);
    load(3'd2, 8'hFF); chk("R9", "hour", hour_byte, 8'hBF);
    load(3'd3, 8'hFF); chk("R9", "date", date_byte, 8'h3F);
    load(3'd4, 8'hFF); chk("R9", "mon", mon_byte, 8'h1F);
    load(3'd5, 8'hFF); chk("R9", "dow", dow_byte, 8'h07);

    // R10 unused address and load priority over a tick
    set_all(8'h42, 8'h03, 8'h15, 8'h02, 8'h10, 8'h30, 8'h20);
    load(3'd7, 8'h55);
    chk("R10", "addr7 sec", sec_byte, 8'h20);  chk("R10", "addr7 min", min_byte, 8'h30);
    chk("R10", "addr7 hour", hour_byte, 8'h10); chk("R10", "addr7 date", date_byte, 8'h15);
    chk("R10", "addr7 mon", mon_byte, 8'h03);  chk("R10", "addr7 dow", dow_byte, 8'h02);
    chk("R10", "addr7 year", year_byte, 8'h42);
    enables(DIV - 1, 0);
    @(negedge clk);
    osc_en = 1'b1; ld_valid = 1'b1; ld_addr = 3'd0; ld_data = 8'h40;
    @(negedge clk);
    osc_en = 1'b0; ld_valid = 1'b0;
    chk("R10", "load wins", sec_byte, 8'h40);
    one_sec();
    chk("R10", "after collide", sec_byte, 8'h41);

    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule